// File: doc/BRIEF.md
# Serial Channel Clock Generation Unit

This block derives the receive and transmit bit-clock enables for one synchronous serial channel. Everything runs from a single fast reference clock. Each clock source is turned into a one-cycle enable on that reference clock. The sources are:

- two external clock pins, each synchronized and edge-detected;
- an internal oscillator tick;
- a programmable baud-rate divider, and a divide-by-16 of its output;
- a bit strobe recovered from the received data by a 16x-oversampling phase counter.

A 3-bit clock-mode field routes these sources to the receive and transmit enables. A second bit chooses the transmit source in the two modes where a choice exists. Both values are captured while reset is held, so a mode change needs a reset.

The transmit clock pin can be turned around and driven with the internal transmit enable. The phase counter is always clocked by the divider output, whichever mode is selected. It re-aligns to every transition seen on the received data.

Top module: `scg_clock_unit`

## Requirements
- R1: `clk_mode` and `tx_alt_sel` are sampled only while `rst` is high. Changing them with `rst` low has no effect on the routing.
- R2: The receive enable is sourced as follows:
  - from the receive pin strobe in modes 0, 1 and 5;
  - from the recovered strobe in modes 2, 3, 6 and 7;
  - from `osc_tick` in mode 4.
- R3: The transmit enable is sourced as follows:
  - from the transmit pin strobe in mode 0;
  - from the divider-over-16 strobe in modes 1 and 5;
  - from the recovered strobe in modes 3 and 7;
  - from `osc_tick` in mode 4.
- R4: In modes 2 and 6, the transmit source is chosen by `tx_alt_sel`. A value of 0 selects the transmit pin strobe and a value of 1 selects the divider-over-16 strobe.
- R5: The divider ratio is set by `baud_div` = N:
  - N = 0 gives a ratio of 1, so there is a divider tick every cycle;
  - any other N gives a ratio of 2·N, capped at 2048.
  - After reset, the first tick comes in the cycle where the counter reads ratio−1.
- R6: The divider-over-16 strobe fires on every 16th divider tick, beginning with the 16th tick after reset.
- R7: The phase counter advances by one on each divider tick. The recovered strobe fires on a tick that finds the phase at 8, so the first one after reset comes on the 9th tick.
- R8: A synchronized transition of either polarity on `rx_data` resets the phase to 0. When a transition and a phase-8 tick fall in the same cycle, the strobe is suppressed.
- R9: Each clock pin passes through a two-flop synchronizer. A rising edge yields exactly one strobe, two reference cycles after the pin changes. A falling edge yields none.
- R10: `tx_clk_oe` is high only when `txpin_drive` is high and the transmit source is not the transmit pin. `tx_clk_out` carries the transmit enable.
- R11: While `rst` is high, both enables and `tx_clk_out` are low. Reset clears all counters and synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; also latches the mode |
| clk_mode | input | 3 | Clock-mode select, values 0 to 7 |
| tx_alt_sel | input | 1 | Transmit source choice for modes 2 and 6 |
| txpin_drive | input | 1 | Turn the transmit clock pin into an output |
| baud_div | input | 11 | Divider setting N |
| rx_clk_in | input | 1 | External receive clock pin |
| tx_clk_in | input | 1 | External transmit clock pin (input direction) |
| osc_tick | input | 1 | Oscillator enable, one reference cycle wide |
| rx_data | input | 1 | Received serial data, for clock recovery |
| rx_bit_en | output | 1 | Receive bit enable |
| tx_bit_en | output | 1 | Transmit bit enable |
| tx_clk_out | output | 1 | Value driven onto the transmit clock pin |
| tx_clk_oe | output | 1 | Output enable for the transmit clock pin |

## Verification
Two events in the recovery logic can land in one cycle: a re-alignment caused by a data transition, and a phase-8 sampling tick. With the divider at ratio 1, the bench toggles `rx_data` so that its synchronized edge arrives exactly at the phase-8 tick. Under R8 this must suppress the strobe and restart the phase, so the first recovered strobe moves from sample 8 to sample 17. A second transition placed two samples earlier must move the first strobe to sample 15. That separates a correct priority from a counter that merely ignores transitions.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_DPLL  = 2'd1,
        SRC_OSC   = 2'd2,
        SRC_BRG16 = 2'd3
    } clk_src_e;

    typedef struct packed {
        clk_src_e rx;
        clk_src_e tx;
    } route_t;

    // Mode decode: receive and transmit source per mode value.
    function automatic route_t route_of(input logic [2:0] mode, input logic alt);
        route_t r;
        case (mode)
            3'd0:         r = '{rx: SRC_PIN,  tx: SRC_PIN};
            3'd1, 3'd5:   r = '{rx: SRC_PIN,  tx: SRC_BRG16};
            3'd2, 3'd6:   r = '{rx: SRC_DPLL, tx: (alt ? SRC_BRG16 : SRC_PIN)};
            3'd3, 3'd7:   r = '{rx: SRC_DPLL, tx: SRC_DPLL};
            default:      r = '{rx: SRC_OSC,  tx: SRC_OSC};
        endcase
        return r;
    endfunction

    function automatic logic pick(input clk_src_e s, input logic pin, input logic dpll,
                                  input logic osc, input logic b16);
        case (s)
            SRC_PIN:  return pin;
            SRC_DPLL: return dpll;
            SRC_OSC:  return osc;
            default:  return b16;
        endcase
    endfunction

endpackage

// File: rtl/scg_edge_sync.sv
module scg_edge_sync #(
    parameter int STAGES   = 2,
    parameter bit ANY_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic strobe
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    generate
        if (ANY_EDGE) begin : g_any
            assign strobe = sh[STAGES-1] ^ sh[STAGES];
        end else begin : g_rise
            assign strobe = sh[STAGES-1] & ~sh[STAGES];
            // R9: a rising edge gives a single strobe
            p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);
        end
    endgenerate
endmodule

// File: rtl/scg_baud_div.sv
module scg_baud_div #(
    parameter int DIV_W     = 11,
    parameter int MAX_RATIO = 2048,
    parameter int OVS       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick,
    output logic             tick16
);
    localparam int RW  = DIV_W + 2;
    localparam int C16 = $clog2(OVS);

    logic [RW-1:0]  ratio;
    logic [RW-1:0]  cnt;
    logic [C16-1:0] c16;

    always_comb begin
        if (div_n == '0)
            ratio = RW'(1);
        else if ({1'b0, div_n, 1'b0} > RW'(MAX_RATIO))
            ratio = RW'(MAX_RATIO);
        else
            ratio = {1'b0, div_n, 1'b0};
    end

    assign tick   = (cnt >= ratio - RW'(1));
    assign tick16 = tick && (c16 == C16'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            c16 <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + RW'(1);
            if (tick) c16 <= c16 + C16'(1);
        end
    end

    // R5: every period ends with the count restarting
    p_tick_restart_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));
    // R6: the over-16 strobe only ever rides on a divider tick
    p_div16_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        tick16 |-> tick);
endmodule

// File: rtl/scg_dpll.sv
module scg_dpll #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic data_edge,
    output logic bit_en
);
    localparam int PW     = $clog2(OVS);
    localparam int SAMPLE = OVS / 2;

    logic [PW-1:0] phase;

    assign bit_en = tick && !data_edge && (phase == PW'(SAMPLE));

    always_ff @(posedge clk) begin
        if (rst)            phase <= '0;
        else if (data_edge) phase <= '0;
        else if (tick)      phase <= phase + PW'(1);
    end

    // R8: a data transition re-aligns the phase
    p_resync_r8: assert property (@(posedge clk) disable iff (rst)
        data_edge |=> (phase == '0));
    // R7: the recovered strobe needs a divider tick
    p_strobe_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        bit_en |-> tick);
endmodule

// File: rtl/scg_clock_unit.sv
module scg_clock_unit
    import scg_pkg::*;
#(
    parameter int DIV_W       = 11,
    parameter int MAX_RATIO   = 2048,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       clk_mode,
    input  logic             tx_alt_sel,
    input  logic             txpin_drive,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rx_clk_in,
    input  logic             tx_clk_in,
    input  logic             osc_tick,
    input  logic             rx_data,
    output logic             rx_bit_en,
    output logic             tx_bit_en,
    output logic             tx_clk_out,
    output logic             tx_clk_oe
);
    localparam int NSYNC = 3;

    logic [2:0]       mode_q;
    logic             alt_q;
    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] strb;
    logic             tick, tick16, dpll_en;
    route_t           rt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= clk_mode;
            alt_q  <= tx_alt_sel;
        end
    end

    // index 0: receive pin, 1: transmit pin, 2: received data (both edges)
    assign raw_in = {rx_data, tx_clk_in, rx_clk_in};

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        scg_edge_sync #(
            .STAGES  (SYNC_STAGES),
            .ANY_EDGE(i == NSYNC - 1)
        ) u_sync (
            .clk   (clk),
            .rst   (rst),
            .din   (raw_in[i]),
            .strobe(strb[i])
        );
    end

    scg_baud_div #(
        .DIV_W    (DIV_W),
        .MAX_RATIO(MAX_RATIO),
        .OVS      (OVS)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .div_n (baud_div),
        .tick  (tick),
        .tick16(tick16)
    );

    scg_dpll #(.OVS(OVS)) u_dpll (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .data_edge(strb[2]),
        .bit_en   (dpll_en)
    );

    always_comb rt = route_of(mode_q, alt_q);

    assign rx_bit_en  = !rst && pick(rt.rx, strb[0], dpll_en, osc_tick, tick16);
    assign tx_bit_en  = !rst && pick(rt.tx, strb[1], dpll_en, osc_tick, tick16);
    assign tx_clk_out = tx_bit_en;
    assign tx_clk_oe  = txpin_drive && (rt.tx != SRC_PIN);

    // R1: the latched mode does not move outside reset
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(mode_q) && $stable(alt_q)));
    // R10: no pin drive without the enable bit
    p_oe_needs_drive_r10: assert property (@(posedge clk) disable iff (rst)
        !txpin_drive |-> !tx_clk_oe);
endmodule

// File: tb/tb_scg_clock_unit.sv
module tb_scg_clock_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  clk_mode = 3'd0;
    logic        tx_alt_sel = 1'b0;
    logic        txpin_drive = 1'b0;
    logic [10:0] baud_div = '0;
    logic        rx_clk_in = 1'b0;
    logic        tx_clk_in = 1'b0;
    logic        osc_tick = 1'b0;
    logic        rx_data = 1'b0;
    logic        rx_bit_en, tx_bit_en, tx_clk_out, tx_clk_oe;

    int checks = 0;
    int errors = 0;

    // stimulus plan: sample index at which each input is changed
    int osc_drv, rxp_rise, rxp_fall, txp_rise, rxd_drv;

    always #10 clk = ~clk;

    scg_clock_unit dut (
        .clk(clk), .rst(rst), .clk_mode(clk_mode), .tx_alt_sel(tx_alt_sel),
        .txpin_drive(txpin_drive), .baud_div(baud_div), .rx_clk_in(rx_clk_in),
        .tx_clk_in(tx_clk_in), .osc_tick(osc_tick), .rx_data(rx_data),
        .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
        .tx_clk_out(tx_clk_out), .tx_clk_oe(tx_clk_oe)
    );

    // {mode, alt, first rx strobe sample, first tx strobe sample}
    // pin rx -> 5, pin tx -> 11, osc -> 2, dpll -> 8, divider/16 -> 15
    localparam logic [15:0] VEC [10] = '{
        {3'd0, 1'b0, 6'd5, 6'd11},
        {3'd1, 1'b0, 6'd5, 6'd15},
        {3'd2, 1'b0, 6'd8, 6'd11},
        {3'd2, 1'b1, 6'd8, 6'd15},
        {3'd3, 1'b0, 6'd8, 6'd8},
        {3'd4, 1'b0, 6'd2, 6'd2},
        {3'd5, 1'b0, 6'd5, 6'd15},
        {3'd6, 1'b0, 6'd8, 6'd11},
        {3'd6, 1'b1, 6'd8, 6'd15},
        {3'd7, 1'b0, 6'd8, 6'd8}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic plan_default();
        osc_drv = 1; rxp_rise = 3; rxp_fall = -1; txp_rise = 9; rxd_drv = -1;
    endtask

    task automatic do_reset(input logic [2:0] m, input logic alt, input logic [10:0] n);
        @(negedge clk);
        rst = 1'b1; clk_mode = m; tx_alt_sel = alt; baud_div = n;
        rx_clk_in = 1'b0; tx_clk_in = 1'b0; osc_tick = 1'b0; rx_data = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    // samples j = 1..n at falling edges; sample j follows j rising edges after release
    task automatic run_window(input int n, output int f_rx, output int f_tx,
                              output int c_rx, output int c_tx);
        f_rx = 0; f_tx = 0; c_rx = 0; c_tx = 0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (rx_bit_en) begin c_rx++; if (f_rx == 0) f_rx = j; end
            if (tx_bit_en) begin c_tx++; if (f_tx == 0) f_tx = j; end
            osc_tick = (j == osc_drv);
            if (j == rxp_rise) rx_clk_in = 1'b1;
            if (j == rxp_fall) rx_clk_in = 1'b0;
            if (j == txp_rise) tx_clk_in = 1'b1;
            if (j == rxd_drv)  rx_data = ~rx_data;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int frx, ftx, crx, ctx;

        // R11: quiet outputs while reset is held
        rst = 1'b1; clk_mode = 3'd4; txpin_drive = 1'b1; osc_tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 rx_bit_en in reset", int'(rx_bit_en), 0);
        check("R11 tx_bit_en in reset", int'(tx_bit_en), 0);
        check("R11 tx_clk_out in reset", int'(tx_clk_out), 0);
        txpin_drive = 1'b0;

        // R2 R3 R4: mode routing table
        plan_default();
        for (int i = 0; i < 10; i++) begin
            do_reset(VEC[i][15:13], VEC[i][12], 11'd0);
            run_window(40, frx, ftx, crx, ctx);
            check($sformatf("R2 rx source mode %0d alt %0d", VEC[i][15:13], VEC[i][12]),
                  frx, int'(VEC[i][11:6]));
            check($sformatf("R3 R4 tx source mode %0d alt %0d", VEC[i][15:13], VEC[i][12]),
                  ftx, int'(VEC[i][5:0]));
        end

        // R1: mode input changed outside reset is ignored (mode 4 keeps osc on rx)
        do_reset(3'd4, 1'b0, 11'd0);
        @(negedge clk);
        clk_mode = 3'd1;
        osc_tick = 1'b1;
        @(negedge clk);
        check("R1 rx still osc after live mode change", int'(rx_bit_en), 1);
        osc_tick = 1'b0;

        // R5: ratio 6 (N=3): ticks at samples 5+6m
        plan_default();
        do_reset(3'd3, 1'b0, 11'd3);
        run_window(60, frx, ftx, crx, ctx);
        check("R5 ratio 6 recovered strobe", ftx, 53);
        do_reset(3'd1, 1'b0, 11'd3);
        run_window(100, frx, ftx, crx, ctx);
        check("R5 R6 ratio 6 divider/16", ftx, 95);

        // R5: clamp, N=2047 acts as 2048
        do_reset(3'd3, 1'b0, 11'd2047);
        run_window(18440, frx, ftx, crx, ctx);
        check("R5 clamp at 2048", ftx, 18431);

        // R6: divider/16 period at ratio 1
        do_reset(3'd1, 1'b0, 11'd0);
        run_window(64, frx, ftx, crx, ctx);
        check("R6 divider/16 count in 64", ctx, 4);

        // R7: recovered strobe period 16 ticks
        do_reset(3'd3, 1'b0, 11'd0);
        run_window(40, frx, ftx, crx, ctx);
        check("R7 recovered strobe count in 40", ctx, 3);

        // R8: transition re-aligns phase
        plan_default(); rxd_drv = 4;
        do_reset(3'd3, 1'b0, 11'd0);
        run_window(20, frx, ftx, crx, ctx);
        check("R8 resync moves strobe", ftx, 15);
        // R8: transition on the phase-8 tick suppresses the strobe
        rxd_drv = 6;
        do_reset(3'd3, 1'b0, 11'd0);
        run_window(20, frx, ftx, crx, ctx);
        check("R8 coincident transition suppresses", ftx, 17);

        // R9: falling edge yields no strobe
        plan_default(); rxp_fall = 20;
        do_reset(3'd0, 1'b0, 11'd0);
        run_window(40, frx, ftx, crx, ctx);
        check("R9 rx pin strobe count", crx, 1);
        check("R9 rx pin latency", frx, 5);

        // R10: pin direction and driven value
        plan_default();
        txpin_drive = 1'b1;
        do_reset(3'd3, 1'b0, 11'd0);
        for (int j = 1; j <= 8; j++) @(negedge clk);
        check("R10 oe with internal tx", int'(tx_clk_oe), 1);
        check("R10 pin carries tx enable", int'(tx_clk_out), 1);
        txpin_drive = 1'b0;
        @(negedge clk);
        check("R10 oe off when drive clear", int'(tx_clk_oe), 0);
        txpin_drive = 1'b1;
        do_reset(3'd0, 1'b0, 11'd0);
        @(negedge clk);
        check("R10 oe off when tx from pin", int'(tx_clk_oe), 0);
        txpin_drive = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule